// File: doc/BRIEF.md
# Counted Rendezvous Synchronization Unit

This block decides when a dataflow node with several inputs may fire. Each arriving token names a rendezvous slot, carries the threshold taken from its instruction's opcode, and carries the two frame offsets that hold the node's operands. The block keeps one arrival counter for each slot. For each accepted token it reads the counter of the named slot and compares it with the threshold. If the counter is below the threshold, the counter goes up by one and nothing is emitted. If it is not below, the node fires: the block emits the two operand offsets and returns the counter to zero.

The counter update is a two-stage read-modify-write pipeline. A token aimed at the same slot as the token one cycle ahead of it takes its count from the writeback stage, so a steady stream of arrivals to a single slot loses no arrivals. A threshold of N fires the node on its (N+1)-th arrival. A threshold of zero therefore fires on every token.

A clear command walks through every slot and zeroes it, one slot per cycle. While this walk runs, `busy` is high and new tokens are dropped.

Top module: `rdv_counted_match`

## Requirements
- R1: After reset every slot counter is zero, `busy` is low and `fire_valid` is low. A slot's first threshold+1 arrivals are needed before it fires.
- R2: An accepted token whose slot count is below its threshold `tok_need` raises that count by one and produces no fire.
- R3: An accepted token whose slot count is greater than or equal to `tok_need` fires and leaves that slot's count at zero.
- R4: A token with `tok_need` equal to 0 fires on every accepted arrival.
- R5: A token accepted in the cycle before clock edge k drives `fire_valid` high after edge k+1, when it fires. At that point `fire_opa` and `fire_opb` equal that token's `tok_opa` and `tok_opb`.
- R6: Tokens to the same slot in consecutive cycles are each counted exactly once.
- R7: Slot counters are independent. Arrivals to one slot never change another slot's count.
- R8: `clr_req` sampled high while `busy` is low raises `busy` from the next edge for exactly SLOTS cycles. When `busy` falls, every counter is zero. A token already inside the pipeline still produces its fire output.
- R9: A token presented while `busy` is high, or in the same cycle as `clr_req`, is dropped. It changes no count and produces no fire.
- R10: `clr_req` while `busy` is high has no effect, and the walk keeps its length of SLOTS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | Token present this cycle |
| tok_slot | input | SLOT_W | Rendezvous slot named by the instruction |
| tok_need | input | CNT_W | Threshold carried in the opcode |
| tok_opa | input | FOFS_W | Frame offset of the first operand |
| tok_opb | input | FOFS_W | Frame offset of the second operand |
| clr_req | input | 1 | Start a clear of all counters |
| busy | output | 1 | Clear walk in progress |
| fire_valid | output | 1 | Node enabled this cycle |
| fire_opa | output | FOFS_W | First operand frame offset of the enabled node |
| fire_opb | output | FOFS_W | Second operand frame offset of the enabled node |

## Verification
On every cycle, assertions check four things:
- every fire traces back to a token presented two cycles earlier while the block was idle;
- a firing writeback leaves its slot at zero;
- the clear walk lasts exactly SLOTS cycles;
- all counters are zero at the end of the clear walk.

Other properties can only be shown by scenarios that compare against a bench model of the counts:
- the exact arrival on which each threshold fires;
- the forwarding of back-to-back arrivals to one slot;
- independence between slots;
- dropping of tokens during a clear;
- survival of a token in flight when a clear starts.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

   // Outcome of one pass through the decision stage
   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_BUMP = 2'd1,
      ACT_FIRE = 2'd2
   } rdv_act_e;

endpackage

// File: rtl/rdv_slot_store.sv
module rdv_slot_store #(
   parameter int SLOTS  = 8,
   parameter int CNT_W  = 3,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [SLOT_W-1:0]      rd_idx,
   output logic [CNT_W-1:0]       rd_cnt,
   input  logic                   wr_en,
   input  logic [SLOT_W-1:0]      wr_idx,
   input  logic [CNT_W-1:0]       wr_cnt,
   input  logic                   clr_start,
   output logic                   busy,
   output logic [SLOTS*CNT_W-1:0] cnt_all
);

   logic              busy_q;
   logic [SLOT_W-1:0] sweep_q;

   // one counter register per slot
   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (busy_q && sweep_q == SLOT_W'(g))
            cnt_q <= '0;
         else if (!busy_q && wr_en && wr_idx == SLOT_W'(g))
            cnt_q <= wr_cnt;
      end
      assign cnt_all[g*CNT_W +: CNT_W] = cnt_q;
   end

   assign rd_cnt = cnt_all[rd_idx*CNT_W +: CNT_W];

   // clear walk: one slot per cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         sweep_q <= '0;
      end else if (busy_q) begin
         if (sweep_q == SLOT_W'(SLOTS - 1)) begin
            busy_q  <= 1'b0;
            sweep_q <= '0;
         end else begin
            sweep_q <= sweep_q + 1'b1;
         end
      end else if (clr_start) begin
         busy_q  <= 1'b1;
         sweep_q <= '0;
      end
   end

   assign busy = busy_q;

   // independent run-length counter for the walk checks
   logic [SLOT_W:0] run_q;
   always_ff @(posedge clk) begin
      if (rst || !busy_q) run_q <= '0;
      else                run_q <= run_q + 1'b1;
   end

   p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (run_q < (SLOT_W+1)'(SLOTS)));

   p_busy_full_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_q) |-> ($past(run_q) == (SLOT_W+1)'(SLOTS - 1)));

   p_sweep_zero_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_q) |-> (cnt_all == '0));

endmodule

// File: rtl/rdv_decide.sv
module rdv_decide
   import rdv_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             valid,
   input  logic [CNT_W-1:0] stored_cnt,
   input  logic             fwd_hit,
   input  logic [CNT_W-1:0] fwd_cnt,
   input  logic [CNT_W-1:0] need,
   output rdv_act_e         act,
   output logic [CNT_W-1:0] next_cnt
);

   logic [CNT_W-1:0] cur;

   always_comb begin
      cur      = fwd_hit ? fwd_cnt : stored_cnt;
      act      = ACT_IDLE;
      next_cnt = cur;
      if (valid) begin
         if (cur < need) begin
            act      = ACT_BUMP;
            next_cnt = cur + 1'b1;
         end else begin
            act      = ACT_FIRE;
            next_cnt = '0;
         end
      end
   end

endmodule

// File: rtl/rdv_counted_match.sv
module rdv_counted_match
   import rdv_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int CNT_W  = 3,
   parameter int FOFS_W = 6,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tok_valid,
   input  logic [SLOT_W-1:0] tok_slot,
   input  logic [CNT_W-1:0]  tok_need,
   input  logic [FOFS_W-1:0] tok_opa,
   input  logic [FOFS_W-1:0] tok_opb,
   input  logic              clr_req,
   output logic              busy,
   output logic              fire_valid,
   output logic [FOFS_W-1:0] fire_opa,
   output logic [FOFS_W-1:0] fire_opb
);

   // elaboration checks
   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (CNT_W < 1 || FOFS_W < 1) begin : g_bad_width
      $error("CNT_W and FOFS_W must be positive");
   end

   logic accept;
   assign accept = tok_valid && !busy && !clr_req;

   // stage 1: captured token, counter read
   logic              s1_v;
   logic [SLOT_W-1:0] s1_slot;
   logic [CNT_W-1:0]  s1_need;
   logic [FOFS_W-1:0] s1_opa, s1_opb;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v <= 1'b0;
      end else begin
         s1_v <= accept;
      end
      s1_slot <= tok_slot;
      s1_need <= tok_need;
      s1_opa  <= tok_opa;
      s1_opb  <= tok_opb;
   end

   // stage 2: writeback
   logic              s2_v;
   logic              s2_fire;
   logic [SLOT_W-1:0] s2_slot;
   logic [CNT_W-1:0]  s2_cnt;
   logic [FOFS_W-1:0] s2_opa, s2_opb;

   logic [CNT_W-1:0]       rd_cnt;
   logic [SLOTS*CNT_W-1:0] cnt_all;
   logic                   fwd_hit;
   rdv_act_e               act;
   logic [CNT_W-1:0]       next_cnt;

   rdv_slot_store #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .rd_idx    (s1_slot),
      .rd_cnt    (rd_cnt),
      .wr_en     (s2_v),
      .wr_idx    (s2_slot),
      .wr_cnt    (s2_cnt),
      .clr_start (clr_req),
      .busy      (busy),
      .cnt_all   (cnt_all)
   );

   // the writeback stage holds a newer count than the store
   assign fwd_hit = s2_v && !busy && (s2_slot == s1_slot);

   rdv_decide #(.CNT_W(CNT_W)) u_decide (
      .valid      (s1_v),
      .stored_cnt (rd_cnt),
      .fwd_hit    (fwd_hit),
      .fwd_cnt    (s2_cnt),
      .need       (s1_need),
      .act        (act),
      .next_cnt   (next_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v    <= 1'b0;
         s2_fire <= 1'b0;
      end else begin
         s2_v    <= s1_v;
         s2_fire <= (act == ACT_FIRE);
      end
      s2_slot <= s1_slot;
      s2_cnt  <= next_cnt;
      s2_opa  <= s1_opa;
      s2_opb  <= s1_opb;
   end

   assign fire_valid = s2_v && s2_fire;
   assign fire_opa   = s2_opa;
   assign fire_opb   = s2_opb;

   function automatic logic [CNT_W-1:0] cnt_at(input logic [SLOTS*CNT_W-1:0] f,
                                               input logic [SLOT_W-1:0] i);
      return f[i*CNT_W +: CNT_W];
   endfunction

   p_fire_lat_r5: assert property (@(posedge clk) disable iff (rst)
      fire_valid |-> ($past(tok_valid, 2) && !$past(clr_req, 2) && !$past(busy, 2)));

   p_fire_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (fire_valid && !busy) |=> (cnt_at(cnt_all, $past(s2_slot)) == '0));

endmodule

// File: tb/rdv_counted_match_tb.sv
`timescale 1ns/1ps
module rdv_counted_match_tb;

   localparam int SLOTS  = 8;
   localparam int CNT_W  = 3;
   localparam int FOFS_W = 6;
   localparam int SLOT_W = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst;
   logic              tok_valid;
   logic [SLOT_W-1:0] tok_slot;
   logic [CNT_W-1:0]  tok_need;
   logic [FOFS_W-1:0] tok_opa, tok_opb;
   logic              clr_req;
   logic              busy, fire_valid;
   logic [FOFS_W-1:0] fire_opa, fire_opb;

   rdv_counted_match #(.SLOTS(SLOTS), .CNT_W(CNT_W), .FOFS_W(FOFS_W)) u_dut (
      .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_slot(tok_slot),
      .tok_need(tok_need), .tok_opa(tok_opa), .tok_opb(tok_opb),
      .clr_req(clr_req), .busy(busy), .fire_valid(fire_valid),
      .fire_opa(fire_opa), .fire_opb(fire_opb)
   );

   int n_run  = 0;
   int n_fail = 0;

   int    m_cnt [SLOTS];
   int    bl = 0;
   logic  p0_v = 1'b0, p1_v = 1'b0;
   int    p0_a = 0, p0_b = 0, p1_a = 0, p1_b = 0;
   string p0_tag = "R1", p1_tag = "R1";

   // One cycle: check outputs, advance the model, drive the next inputs
   task automatic step(input logic v, input int slot, input int need,
                       input int a, input int b, input logic clr, input string tag);
      logic exp_busy;
      logic fire;
      @(negedge clk);
      n_run++;
      if (fire_valid !== p1_v || (p1_v && (fire_opa !== FOFS_W'(p1_a) || fire_opb !== FOFS_W'(p1_b)))) begin
         n_fail++;
         $display("FAIL %s fire v/opa/opb actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
                  p1_tag, fire_valid, fire_opa, fire_opb, p1_v, p1_a, p1_b);
      end
      exp_busy = (bl > 0);
      n_run++;
      if (busy !== exp_busy) begin
         n_fail++;
         $display("FAIL R8 busy actual=%0b expected=%0b", busy, exp_busy);
      end
      p1_v = p0_v; p1_a = p0_a; p1_b = p0_b; p1_tag = p0_tag;
      fire = 1'b0;
      if (v && !exp_busy && !clr) begin
         if (m_cnt[slot] < need) m_cnt[slot] = m_cnt[slot] + 1;
         else begin m_cnt[slot] = 0; fire = 1'b1; end
      end
      p0_v = fire; p0_a = a & 63; p0_b = b & 63; p0_tag = tag;
      if (bl > 0) bl--;
      if (clr && !exp_busy) begin
         bl = SLOTS;
         for (int i = 0; i < SLOTS; i++) m_cnt[i] = 0;
      end
      tok_valid = v;
      tok_slot  = SLOT_W'(slot);
      tok_need  = CNT_W'(need);
      tok_opa   = FOFS_W'(a & 63);
      tok_opb   = FOFS_W'(b & 63);
      clr_req   = clr;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, 1'b0, tag);
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) m_cnt[i] = 0;
      rst = 1'b1; tok_valid = 1'b0; tok_slot = '0; tok_need = '0;
      tok_opa = '0; tok_opb = '0; clr_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state and counts starting from zero
      idle(2, "R1");
      step(1'b1, 5, 1, 11, 12, 1'b0, "R1");
      idle(1, "R1");
      step(1'b1, 5, 1, 13, 14, 1'b0, "R1");
      idle(2, "R1");

      // R2/R3/R4: every slot, every threshold, spaced arrivals
      for (int s = 0; s < SLOTS; s++)
         for (int n = 0; n < (1 << CNT_W); n++)
            for (int k = 0; k <= n; k++) begin
               step(1'b1, s, n, s*8 + n, k + 17, 1'b0,
                    (n == 0) ? "R4" : ((k == n) ? "R3" : "R2"));
               idle(1, "R2");
            end
      idle(2, "R3");

      // R6: back-to-back arrivals to one slot
      for (int r = 0; r < 3; r++)
         for (int k = 0; k < 4; k++) step(1'b1, 3, 3, k + 1, r + 40, 1'b0, "R6");
      for (int k = 0; k < 6; k++) step(1'b1, 1, 1, k + 20, k + 30, 1'b0, "R6");
      idle(2, "R6");

      // R7: interleaved slots with different thresholds
      for (int r = 0; r < 6; r++)
         for (int s = 0; s < SLOTS; s += 2)
            step(1'b1, s, s/2 + 1, r*4 + s, 60 - r, 1'b0, "R7");
      idle(2, "R7");
      for (int s = 0; s < SLOTS; s += 2)
         for (int k = 0; k < 5; k++) step(1'b1, s, s/2 + 1, 50 + k, s, 1'b0, "R7");
      idle(2, "R7");

      // R8/R9/R10: clear with partial counts, token in flight, dropped tokens
      for (int k = 0; k < 3; k++) step(1'b1, 2, 5, k, k, 1'b0, "R8");
      step(1'b1, 4, 0, 33, 34, 1'b0, "R8");
      step(1'b1, 2, 0, 35, 36, 1'b1, "R9");
      step(1'b1, 2, 0, 37, 38, 1'b0, "R9");
      step(1'b1, 6, 0, 39, 40, 1'b0, "R9");
      step(1'b0, 0, 0, 0, 0, 1'b1, "R10");
      idle(SLOTS, "R10");
      for (int k = 0; k < 6; k++) begin
         step(1'b1, 2, 5, k + 1, k + 2, 1'b0, "R8");
         idle(1, "R8");
      end
      idle(3, "R8");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8.0 * 150000);
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule